// File: doc/BRIEF.md
# Partitioned SIMD Lane Shifter

This block shifts a 64-bit word as a set of independent lanes. All lanes move by one common count. The lanes are 16, 32 or 64 bits wide, and a bit never crosses from one lane into its neighbour. It offers three shifts:

- left shift with zero fill;
- right shift with zero fill;
- right shift that refills each lane with that lane's own top bit.

When the count is at or above the lane width, the lane is settled as a whole. A shift with zero fill clears it. The sign-filling shift sets every bit of the lane to its sign.

Four bitwise operations share the same datapath: AND, complement-AND, OR and XOR. They act on all 64 bits together and ignore the lane size and the count.

A request is a valid strobe together with the operand(s), an operation code, a size code and a count. The result, a valid flag and an illegal-operation flag are registered one cycle later. For a combination that is not offered, the block passes the first operand through unchanged and raises the illegal flag.

Top module: `lane_shifter`

## Requirements
- R1: While `rst` is high and after it, until the first accepted request, `out_valid`, `out_illegal` and `out_data` are all zero.
- R2: `out_valid` equals the `in_valid` of the previous clock cycle. `out_data` and `out_illegal` are updated only on the clock edge that captures a valid request; otherwise they hold their last values.
- R3: The size code sets the lane width: `in_size`=0 gives four 16-bit lanes, 1 gives two 32-bit lanes, 2 gives one 64-bit lane. Lane k covers bits [k*W+W-1 : k*W]. No bit of a shift result comes from outside its own lane.
- R4: `in_op`=0 shifts each lane left by `in_cnt`. Bits leaving the top of a lane are lost, and zeros enter at the bottom.
- R5: `in_op`=1 shifts each lane right by `in_cnt`, and zeros enter at the top of the lane.
- R6: `in_op`=2 shifts each lane right by `in_cnt`. Copies of that lane's top bit enter at the top of the lane.
- R7: When `in_cnt` is greater than or equal to the lane width, `in_op`=0 and `in_op`=1 give an all-zero lane. `in_op`=2 gives a lane filled with its own top bit.
- R8: `in_op`=2 with `in_size`=2 is illegal. The result equals `in_a`, and `out_illegal`=1.
- R9: `in_op`=4 gives `in_a & in_b`, 5 gives `~in_a & in_b`, 6 gives `in_a | in_b` and 7 gives `in_a ^ in_b`. For these codes `out_illegal`=0, whatever `in_size` and `in_cnt` are.
- R10: `in_op`=3 (any size), and any shift code 0 to 2 with `in_size`=3, is illegal. The result equals `in_a`, and `out_illegal`=1.
- R11: Every legal operation gives `out_illegal`=0. A legal shift with `in_cnt`=0 returns `in_a` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 3 | Operation code (0 left, 1 right zero-fill, 2 right sign-fill, 3 reserved, 4 AND, 5 complement-AND, 6 OR, 7 XOR) |
| in_size | input | 2 | Lane size code (0 16-bit, 1 32-bit, 2 64-bit, 3 reserved) |
| in_cnt | input | CNT_W (7) | Common shift count |
| in_a | input | DATA_W (64) | Operand shifted, first operand of the bitwise operations |
| in_b | input | DATA_W (64) | Second operand of the bitwise operations |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_data | output | DATA_W (64) | Registered result |
| out_illegal | output | 1 | Registered illegal-combination flag |

## Verification
The bench sweeps every size code and every shift code against counts 0 to 72 and 127, using operands whose lane top bits differ from their neighbours. This catches three classes of fault:

- A shifter that lets bits leak between lanes, for example one that shifts the whole word and then masks, shows foreign bits next to a lane edge.
- A sign-filling shift that takes the top bit of the whole word fills the wrong value into the lower lanes.
- Counts at and past the lane width expose a design that wraps the count modulo the width instead of clearing or sign-filling the lane.

The reserved codes and the 64-bit sign-filling shift must hand back `in_a` with the flag raised. A design that decoded them as ordinary shifts would return shifted data. The bitwise codes run with random sizes and counts, which catches any leakage of lane logic into them. Idle cycles with changing inputs show whether the result register is loaded without a valid strobe.

// File: rtl/lsh_pkg.sv
package lsh_pkg;
  typedef enum logic [2:0] {
    OP_SLL  = 3'd0,
    OP_SRL  = 3'd1,
    OP_SRA  = 3'd2,
    OP_RSV  = 3'd3,
    OP_AND  = 3'd4,
    OP_ANDN = 3'd5,
    OP_OR   = 3'd6,
    OP_XOR  = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    SZ_16  = 2'd0,
    SZ_32  = 2'd1,
    SZ_64  = 2'd2,
    SZ_RSV = 2'd3
  } sz_e;

  localparam int NUM_SIZES = 3;
endpackage

// File: rtl/lane_shift_unit.sv
// One lane of the shifter. mode: 0 left, 1 right zero-fill, 2 right sign-fill,
// 3 pass-through.
module lane_shift_unit #(
  parameter int LW    = 16,
  parameter int CNT_W = 7
) (
  input  logic [LW-1:0]    din,
  input  logic [CNT_W-1:0] cnt,
  input  logic [1:0]       mode,
  output logic [LW-1:0]    dout
);
  logic oversize;
  logic sign;

  always_comb begin
    oversize = (int'(cnt) >= LW);
    sign     = din[LW-1];
    unique case (mode)
      2'd0:    dout = oversize ? '0 : (din << cnt);
      2'd1:    dout = oversize ? '0 : (din >> cnt);
      2'd2:    dout = oversize ? {LW{sign}} : LW'($signed(din) >>> cnt);
      default: dout = din;
    endcase
  end
endmodule

// File: rtl/lane_logic_unit.sv
// Full-width bitwise operations: sel 0 AND, 1 complement-AND, 2 OR, 3 XOR.
module lane_logic_unit #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [1:0]        sel,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    unique case (sel)
      2'd0:    y = a & b;
      2'd1:    y = ~a & b;
      2'd2:    y = a | b;
      default: y = a ^ b;
    endcase
  end
endmodule

// File: rtl/lane_shifter.sv
module lane_shifter
  import lsh_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        in_op,
  input  logic [1:0]        in_size,
  input  logic [CNT_W-1:0]  in_cnt,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_illegal
);
  op_e op;
  sz_e sz;
  assign op = op_e'(in_op);
  assign sz = sz_e'(in_size);

  logic [1:0]        shift_mode;
  logic [DATA_W-1:0] sh_res [NUM_SIZES];
  logic [DATA_W-1:0] logic_y;
  logic [DATA_W-1:0] res_c;
  logic              illegal_c;

  assign shift_mode = in_op[1:0];

  // One bank of lane units per size; size index s gives lanes of DATA_W >> (2-s).
  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int LW = DATA_W >> (NUM_SIZES - 1 - s);
    localparam int NL = DATA_W / LW;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      lane_shift_unit #(.LW(LW), .CNT_W(CNT_W)) u_lane (
        .din  (in_a[l*LW +: LW]),
        .cnt  (in_cnt),
        .mode (shift_mode),
        .dout (sh_res[s][l*LW +: LW])
      );
    end
  end

  lane_logic_unit #(.DATA_W(DATA_W)) u_logic (
    .a   (in_a),
    .b   (in_b),
    .sel (in_op[1:0]),
    .y   (logic_y)
  );

  always_comb begin
    res_c     = in_a;
    illegal_c = 1'b0;
    if (in_op[2]) begin
      res_c = logic_y;
    end else if (op == OP_RSV || sz == SZ_RSV || (op == OP_SRA && sz == SZ_64)) begin
      illegal_c = 1'b1;
    end else begin
      unique case (sz)
        SZ_16:   res_c = sh_res[0];
        SZ_32:   res_c = sh_res[1];
        default: res_c = sh_res[2];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_illegal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data    <= res_c;
        out_illegal <= illegal_c;
      end
    end
  end
endmodule

// File: rtl/lane_shifter_chk.sv
module lane_shifter_chk #(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [2:0]        in_op,
  input logic [1:0]        in_size,
  input logic [CNT_W-1:0]  in_cnt,
  input logic [DATA_W-1:0] in_a,
  input logic [DATA_W-1:0] in_b,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_illegal
);
  logic legal_shift;
  assign legal_shift = (in_op <= 3'd2) && (in_size != 2'd3) &&
                       !(in_op == 3'd2 && in_size == 2'd2);

  a_r2_valid_delay: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> out_valid == $past(in_valid));

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data) && $stable(out_illegal));

  a_r8_sra64_passthrough: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_op == 3'd2 && in_size == 2'd2 |=>
      out_illegal && out_data == $past(in_a));

  a_r9_and_full_width: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_op == 3'd4 |=>
      !out_illegal && out_data == ($past(in_a) & $past(in_b)));

  a_r7_left_clears_all: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_op == 3'd0 && in_size != 2'd3 && int'(in_cnt) >= DATA_W |=>
      out_data == '0);

  a_r11_zero_count_identity: assert property (@(posedge clk) disable iff (rst)
    in_valid && legal_shift && in_cnt == '0 |=>
      !out_illegal && out_data == $past(in_a));
endmodule

bind lane_shifter lane_shifter_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_op       (in_op),
  .in_size     (in_size),
  .in_cnt      (in_cnt),
  .in_a        (in_a),
  .in_b        (in_b),
  .out_valid   (out_valid),
  .out_data    (out_data),
  .out_illegal (out_illegal)
);

// File: tb/lane_shifter_bench.sv
module lane_shifter_bench;
  localparam int PERIOD = 10;
  localparam int DW     = 64;
  localparam int CW     = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [2:0]    in_op = '0;
  logic [1:0]    in_size = '0;
  logic [CW-1:0] in_cnt = '0;
  logic [DW-1:0] in_a = '0;
  logic [DW-1:0] in_b = '0;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic          out_illegal;

  int checks = 0;
  int errors = 0;
  logic [63:0] lfsr = 64'hACE1_2468_9BDF_1357;

  always #(PERIOD/2) clk = ~clk;

  lane_shifter #(.DATA_W(DW), .CNT_W(CW)) u_lane_shifter (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_size(in_size),
    .in_cnt(in_cnt), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_data(out_data), .out_illegal(out_illegal)
  );

  function automatic logic [63:0] next_rand(logic [63:0] v);
    return {v[62:0], v[63] ^ v[62] ^ v[60] ^ v[59]};
  endfunction

  // Expected {illegal, data} computed bit by bit from the requirements.
  function automatic logic [64:0] model(logic [63:0] a, logic [63:0] b, int op, int sz, int c);
    logic [63:0] r;
    int lw;
    r = a;
    if (op >= 4) begin
      case (op)
        4: r = a & b;
        5: r = ~a & b;
        6: r = a | b;
        default: r = a ^ b;
      endcase
      return {1'b0, r};
    end
    if (op == 3 || sz == 3 || (op == 2 && sz == 2)) return {1'b1, a};
    lw = (sz == 0) ? 16 : (sz == 1) ? 32 : 64;
    for (int i = 0; i < 64; i++) begin
      int base = (i / lw) * lw;
      int pos  = i - base;
      if (op == 0) r[i] = (pos - c >= 0) ? a[base + pos - c] : 1'b0;
      else if (op == 1) r[i] = (pos + c < lw) ? a[base + pos + c] : 1'b0;
      else r[i] = (pos + c < lw) ? a[base + pos + c] : a[base + lw - 1];
    end
    return {1'b0, r};
  endfunction

  task automatic check(bit ok, string req, logic [64:0] act, logic [64:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(int op, int sz, int c);
    int lw = (sz == 0) ? 16 : (sz == 1) ? 32 : 64;
    if (op >= 4) return "R9 bitwise";
    if (op == 3 || sz == 3) return "R10 reserved";
    if (op == 2 && sz == 2) return "R8 sign-fill on 64";
    if (c == 0) return "R11 zero count";
    if (c >= lw) return "R7 oversize count";
    if (op == 0) return "R4 left shift (R3 lanes)";
    if (op == 1) return "R5 right zero-fill (R3 lanes)";
    return "R6 right sign-fill (R3 lanes)";
  endfunction

  task automatic apply(int op, int sz, int c, logic [63:0] a, logic [63:0] b);
    logic [64:0] exp;
    in_valid = 1'b1;
    in_op    = 3'(op);
    in_size  = 2'(sz);
    in_cnt   = CW'(c);
    in_a     = a;
    in_b     = b;
    exp      = model(a, b, op, sz, c);
    @(negedge clk);
    check(out_valid === 1'b1, "R2 valid one cycle later", {64'd0, out_valid}, 65'd1);
    check({out_illegal, out_data} === exp, req_of(op, sz, c), {out_illegal, out_data}, exp);
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] pats [4];
    logic [63:0] held;
    logic        held_ill;
    pats[0] = 64'h8000_7FFF_FFFF_0001;
    pats[1] = 64'hF0F0_0F0F_8421_1248;
    pats[2] = 64'h7FFF_8000_0000_FFFF;
    pats[3] = 64'h1234_F678_9ABC_DEF0;

    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid === 1'b0, "R1 reset valid", {64'd0, out_valid}, 65'd0);
    check(out_illegal === 1'b0, "R1 reset illegal", {64'd0, out_illegal}, 65'd0);
    check(out_data === '0, "R1 reset data", {1'b0, out_data}, 65'd0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid === 1'b0 && out_data === '0, "R1 idle after reset",
          {out_valid, out_data}, 65'd0);

    // Shift codes (and reserved code 3) over every size and counts 0..72 and 127.
    for (int sz = 0; sz < 4; sz++)
      for (int op = 0; op < 4; op++)
        for (int ci = 0; ci <= 73; ci++)
          for (int p = 0; p < 5; p++) begin
            int c = (ci == 73) ? 127 : ci;
            logic [63:0] a = (p < 4) ? pats[p] : lfsr;
            lfsr = next_rand(lfsr);
            apply(op, sz, c, a, lfsr);
          end

    // Bitwise codes with random size and count.
    for (int op = 4; op < 8; op++)
      for (int k = 0; k < 40; k++) begin
        logic [63:0] a;
        lfsr = next_rand(lfsr);
        a = lfsr;
        lfsr = next_rand(lfsr);
        apply(op, k % 4, (k * 13) % 128, a, lfsr);
      end

    // R2: idle cycles with changing inputs leave the result untouched.
    apply(3, 0, 5, 64'hDEAD_BEEF_0BAD_F00D, 64'h0);
    held     = out_data;
    held_ill = out_illegal;
    in_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      in_op = 3'(k);
      in_a  = ~held + 64'(k);
      @(negedge clk);
      check(out_valid === 1'b0, "R2 valid drops", {64'd0, out_valid}, 65'd0);
      check(out_data === held && out_illegal === held_ill, "R2 hold when idle",
            {out_illegal, out_data}, {held_ill, held});
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule